// File: doc/BRIEF.md
# Sixteen-Bit Adder/Subtractor with Status Word

This block performs a two's-complement add or subtract on a pair of operands, or passes the first operand through, and keeps a 16-bit status word beside the result. The status word carries six condition bits that describe the last arithmetic result. It also carries three control bits, which change only when they are written explicitly.

On each clock edge the operation chosen by `op_sel` is applied to `opa` and `opb`. The outcome appears on `result` one cycle later. When `upd_en` is high during an add or subtract, the condition bits are reloaded from that operation in the same edge. The control bits (single-step trap, interrupt enable, string direction) are loaded from `ctl_wdata` whenever `ctl_we` is high. A condition update and a control write may happen together. All outputs are registered, and the reset is synchronous and active high.

Top module: `alu_flags_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `result` and `flags` become 0x0000.
- R2: `op_sel`=2'b01 adds. The next `result` is (opa+opb) mod 2^16. With `upd_en` high, flags bit 0 (carry) is set when the true sum exceeds 0xFFFF.
- R3: `op_sel`=2'b10 subtracts. The next `result` is (opa-opb) mod 2^16. With `upd_en` high, flags bit 0 is set when opa < opb, taken as unsigned values (a borrow).
- R4: On an updating add, flags bit 4 is set when the sum of the low nibbles of the operands exceeds 15. On an updating subtract, it is set when the low nibble of opa is less than the low nibble of opb.
- R5: On an updating operation, flags bit 2 is 1 when result bits 7:0 hold an even number of ones, and 0 otherwise.
- R6: On an updating operation, flags bit 6 is 1 when the result is zero, and flags bit 7 equals result bit 15.
- R7: On an updating operation, flags bit 11 is set on signed overflow. For an add, this means the operands have equal signs and the result sign differs from them. For a subtract, it means the operand signs differ and the result sign differs from opa.
- R8: With `upd_en` low, or with a pass operation (`op_sel` 2'b00 or 2'b11), bits 0, 2, 4, 6, 7 and 11 keep their values. A pass operation sets `result` to opa.
- R9: Flags bits 8, 9 and 10 load from `ctl_wdata[0]`, `ctl_wdata[1]` and `ctl_wdata[2]` when `ctl_we` is high, and hold otherwise.
- R10: Flags bits 1, 3, 5 and 12 to 15 always read 0.
- R11: When a condition update and a control write occur in the same cycle, both take effect in that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 2 | 00 pass, 01 add, 10 subtract, 11 pass |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| upd_en | input | 1 | Condition-flag update strobe |
| ctl_we | input | 1 | Control-flag write enable |
| ctl_wdata | input | 3 | {direction, interrupt enable, trap} |
| result | output | 16 | Registered result |
| flags | output | 16 | Registered status word |

## Verification
A condition update and a control-bit write can land on the same clock edge, and they target disjoint bits of one register. The bench drives an updating subtract together with a control write. It then compares the whole status word against a model in which both changes are present. Neighbouring cycles drive each path alone: a control write with no update, and an update whose control data is ignored. These cycles show that neither path disturbs the other's bits.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int FLAG_W = 16;

  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_PASS2 = 2'b11
  } op_e;

  // status word bit positions
  localparam int FB_CARRY  = 0;
  localparam int FB_PAR    = 2;
  localparam int FB_HALF   = 4;
  localparam int FB_ZERO   = 6;
  localparam int FB_SIGN   = 7;
  localparam int FB_TRAP   = 8;
  localparam int FB_IEN    = 9;
  localparam int FB_DIR    = 10;
  localparam int FB_OVF    = 11;

  localparam logic [FLAG_W-1:0] UNDEF_MASK = 16'hF02A;
  localparam logic [FLAG_W-1:0] COND_MASK  = 16'h08D5;
  localparam logic [FLAG_W-1:0] CTL_MASK   = 16'h0700;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic half;
    logic par;
    logic carry;
  } cond_t;

endpackage

// File: rtl/alu_arith_core.sv
module alu_arith_core #(
  parameter int W   = 16,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         c_msb,
  output logic         c_nib
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;

  assign b_eff = sub ? ~b : b;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
  assign sum   = full[W-1:0];
  assign c_out = full[W];
  // carry entering a bit = a ^ b ^ sum at that bit
  assign c_msb = a[W-1] ^ b_eff[W-1] ^ sum[W-1];
  assign c_nib = a[NIB] ^ b_eff[NIB] ^ sum[NIB];
endmodule

// File: rtl/alu_cond_gen.sv
module alu_cond_gen
  import alu_flag_pkg::*;
#(
  parameter int W      = 16,
  parameter int PAR_W  = 8
) (
  input  logic [W-1:0] sum,
  input  logic         sub,
  input  logic         c_out,
  input  logic         c_msb,
  input  logic         c_nib,
  output cond_t        cond
);
  always_comb begin
    cond.carry = c_out ^ sub;
    cond.half  = c_nib ^ sub;
    cond.ovf   = c_msb ^ c_out;
    cond.zero  = (sum == '0);
    cond.sign  = sum[W-1];
    cond.par   = ~^sum[PAR_W-1:0];
  end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cond_we,
  input  cond_t             cond,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_d,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      if (cond_we) begin
        flags_q[FB_CARRY] <= cond.carry;
        flags_q[FB_PAR]   <= cond.par;
        flags_q[FB_HALF]  <= cond.half;
        flags_q[FB_ZERO]  <= cond.zero;
        flags_q[FB_SIGN]  <= cond.sign;
        flags_q[FB_OVF]   <= cond.ovf;
      end
      if (ctl_we) begin
        flags_q[FB_TRAP] <= ctl_d[0];
        flags_q[FB_IEN]  <= ctl_d[1];
        flags_q[FB_DIR]  <= ctl_d[2];
      end
    end
  end

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
    (flags_q & UNDEF_MASK) == '0);

  a_r9_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_we |=> $stable(flags_q & CTL_MASK));

  a_r9_ctl_load: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> flags_q[FB_DIR:FB_TRAP] == $past(ctl_d));

  a_r8_cond_hold: assert property (@(posedge clk) disable iff (rst)
    !cond_we |=> $stable(flags_q & COND_MASK));
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flag_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         upd_en,
  input  logic         ctl_we,
  input  logic [2:0]   ctl_wdata,
  output logic [W-1:0] result,
  output logic [15:0]  flags
);
  localparam int NIB   = 4;
  localparam int PAR_W = 8;

  op_e          op;
  logic         is_arith;
  logic         is_sub;
  logic [W-1:0] sum;
  logic         c_out, c_msb, c_nib;
  cond_t        cond;
  logic         cond_we;
  logic [W-1:0] res_q;

  assign op       = op_e'(op_sel);
  assign is_sub   = (op == OP_SUB);
  assign is_arith = (op == OP_ADD) || is_sub;
  assign cond_we  = upd_en && is_arith;

  alu_arith_core #(.W(W), .NIB(NIB)) u_core (
    .a(opa), .b(opb), .sub(is_sub),
    .sum(sum), .c_out(c_out), .c_msb(c_msb), .c_nib(c_nib)
  );

  alu_cond_gen #(.W(W), .PAR_W(PAR_W)) u_cond (
    .sum(sum), .sub(is_sub), .c_out(c_out), .c_msb(c_msb),
    .c_nib(c_nib), .cond(cond)
  );

  alu_flag_reg u_flags (
    .clk(clk), .rst(rst), .cond_we(cond_we), .cond(cond),
    .ctl_we(ctl_we), .ctl_d(ctl_wdata), .flags_q(flags)
  );

  always_ff @(posedge clk) begin
    if (rst)           res_q <= '0;
    else if (is_arith) res_q <= sum;
    else               res_q <= opa;
  end

  assign result = res_q;

  a_r6_zero_tracks: assert property (@(posedge clk) disable iff (rst)
    cond_we |=> flags[FB_ZERO] == (result == '0));

  a_r6_sign_tracks: assert property (@(posedge clk) disable iff (rst)
    cond_we |=> flags[FB_SIGN] == result[W-1]);

  a_r3_borrow: assert property (@(posedge clk) disable iff (rst)
    (upd_en && op == OP_SUB) |=> flags[FB_CARRY] == ($past(opa) < $past(opb)));

  a_r8_pass_copies: assert property (@(posedge clk) disable iff (rst)
    !is_arith |=> result == $past(opa));
endmodule

// File: tb/test_alu_flags_unit.sv
module test_alu_flags_unit;
  typedef struct {
    logic [15:0] r;
    logic [15:0] f;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  op_sel = 0;
  logic [15:0] opa = 0, opb = 0;
  logic        upd_en = 0, ctl_we = 0;
  logic [2:0]  ctl_wdata = 0;
  logic [15:0] result, flags;

  int n_cmp = 0;
  int n_bad = 0;
  exp_t q[$];
  logic [15:0] mdl_f = 0;

  always #5 clk = ~clk;

  alu_flags_unit i_alu_flags_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .upd_en(upd_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .result(result), .flags(flags)
  );

  task automatic check(string tag, logic [15:0] r, logic [15:0] f,
                       logic [15:0] er, logic [15:0] ef);
    n_cmp++;
    if (r !== er || f !== ef) begin
      n_bad++;
      $display("FAIL %s: result=%h flags=%h expected result=%h flags=%h",
               tag, r, f, er, ef);
    end
  endtask

  task automatic step(logic [1:0] op, logic [15:0] a, logic [15:0] b,
                      logic upd, logic cwe, logic [2:0] cw, string tag);
    exp_t e;
    int   s;
    logic [15:0] r;
    logic cf, af, of;
    @(negedge clk);
    op_sel = op; opa = a; opb = b; upd_en = upd; ctl_we = cwe; ctl_wdata = cw;
    cf = 0; af = 0; of = 0;
    if (op == 2'b01) begin
      s  = int'(a) + int'(b);
      r  = s[15:0];
      cf = s > 65535;
      af = (a[3:0] + b[3:0]) > 15;
      of = (a[15] == b[15]) && (r[15] != a[15]);
    end else if (op == 2'b10) begin
      r  = a - b;
      cf = a < b;
      af = a[3:0] < b[3:0];
      of = (a[15] != b[15]) && (r[15] != a[15]);
    end else begin
      r = a;
    end
    if (upd && (op == 2'b01 || op == 2'b10)) begin
      mdl_f[0]  = cf;
      mdl_f[2]  = ~^r[7:0];
      mdl_f[4]  = af;
      mdl_f[6]  = (r == 0);
      mdl_f[7]  = r[15];
      mdl_f[11] = of;
    end
    if (cwe) mdl_f[10:8] = cw;
    e.r = r; e.f = mdl_f; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare one expected item per cycle, 2 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, result, flags, e.r, e.f);
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: result=%h flags=%h expected completion", result, flags);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // drive busy inputs during reset; R1 says outputs stay zero
    op_sel = 2'b01; opa = 16'h8001; opb = 16'h8001; upd_en = 1;
    ctl_we = 1; ctl_wdata = 3'b111;
    repeat (3) @(negedge clk);
    check("R1 reset", result, flags, 16'h0000, 16'h0000);
    rst = 0; upd_en = 0; ctl_we = 0; op_sel = 0;

    step(2'b01, 16'h34DC, 16'h072E, 1, 0, 3'b000, "R2 R4 R5 add example");
    step(2'b01, 16'hFFE5, 16'hFFB1, 1, 0, 3'b000, "R2 R6 carry sign");
    step(2'b10, 16'h0005, 16'h0007, 1, 0, 3'b000, "R3 borrow");
    step(2'b10, 16'h1234, 16'h1234, 1, 0, 3'b000, "R6 zero");
    step(2'b01, 16'h7FFF, 16'h0001, 1, 0, 3'b000, "R7 add overflow");
    step(2'b10, 16'h8000, 16'h0001, 1, 0, 3'b000, "R7 sub overflow");
    step(2'b01, 16'h000F, 16'h0001, 1, 0, 3'b000, "R4 nibble carry");
    step(2'b10, 16'h0010, 16'h0001, 1, 0, 3'b000, "R4 nibble borrow");
    step(2'b01, 16'h0001, 16'h0000, 1, 0, 3'b000, "R5 odd parity");
    step(2'b01, 16'hFFFF, 16'h0001, 0, 0, 3'b000, "R8 strobe low holds");
    step(2'b00, 16'hABCD, 16'h0000, 1, 0, 3'b000, "R8 pass holds");
    step(2'b11, 16'h0000, 16'h1111, 1, 0, 3'b000, "R8 alt pass");
    step(2'b00, 16'h0000, 16'h0000, 0, 1, 3'b101, "R9 ctl write");
    step(2'b01, 16'h0100, 16'h0200, 1, 0, 3'b010, "R9 ctl ignored R10");
    step(2'b10, 16'h0000, 16'h0001, 1, 1, 3'b010, "R11 same cycle");
    step(2'b10, 16'h4000, 16'hC000, 1, 1, 3'b001, "R11 R7 same cycle");
    step(2'b01, 16'h8000, 16'h8000, 1, 0, 3'b000, "R2 R6 R7 wrap zero");
    step(2'b00, 16'h0000, 16'h0000, 0, 0, 3'b000, "R10 idle");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule